// File: doc/BRIEF.md
# Serial Binary-to-Decimal Digit Converter

This block turns an unsigned binary value into its decimal digits and hands them out one at a time on a narrow digit bus. A load strobe captures a new value, clears every output and starts a conversion. The digits come out most significant first, each marked by a one-cycle ready pulse. The last digit carries a done flag that stays up until the next load or reset.

Each digit is found by subtracting the current power of ten from a working remainder, one subtraction per clock, while a count tracks how many subtractions fit. When the remainder drops below the power, the count is the digit. The block then idles one cycle and moves to the next lower power. A load that arrives during a conversion abandons it and starts over with the new value. With the default 8-bit input, the block emits three digits (hundreds, tens, units), and leading zeros are kept.

Top module: `bin_dec_serial`

## Requirements
- R1: Asserting rst_n low clears digit_o, digit_vld_o and done_o at once, without waiting for a clock edge. After rst_n rises, all three stay zero until a load.
- R2: For an 8-bit input, exactly three digits are emitted per conversion, in the order hundreds, tens, units, with leading zeros included. Each digit is presented on digit_o as a plain binary value from 0 to 9.
- R3: digit_vld_o is never high in two consecutive cycles.
- R4: done_o rises in the same cycle as the units digit's digit_vld_o pulse. It stays high until the next load or reset.
- R5: Counting the edge that samples load_i as edge 0, the hundreds digit h is valid after edge h+1. Each later digit d is valid d+2 edges after the previous digit.
- R6: In the cycle after load_i is sampled high, digit_o, digit_vld_o and done_o are all zero.
- R7: While digit_vld_o is low, digit_o keeps its previous value, unless load_i or reset acted in the previous cycle.
- R8: A load during a conversion abandons that conversion. Only the new value's digits then appear, with the timing of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Load strobe: capture value_i and start converting |
| value_i | input | IN_W (8) | Unsigned binary value to convert |
| digit_o | output | DIG_W (4) | Current decimal digit |
| digit_vld_o | output | 1 | One-cycle pulse marking a new digit on digit_o |
| done_o | output | 1 | Conversion complete; held until the next load or reset |

## Verification
The bench builds the block with its default parameters: IN_W of 8 and DIG_W of 4. This gives three digit places and powers of 100, 10 and 1. These values bring into reach the zero-length subtraction runs (inputs 0, 10, 100) and the longest runs (255, 99). The bench compares every cycle against a behavioural model that schedules the expected digits from a queue of the input's decimal digits. The runs cover loads that abort a conversion mid-way and an asynchronous reset applied during a conversion.

// File: rtl/bds_pkg.sv
package bds_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } conv_state_e;

  // Decimal digits needed for the largest value of a w-bit word.
  function automatic int digits_for_width(input int w);
    longint m;
    int n;
    m = (longint'(1) << w) - 1;
    n = 1;
    while (m >= 10) begin
      m = m / 10;
      n = n + 1;
    end
    return n;
  endfunction

  function automatic longint pow10(input int e);
    longint r;
    r = 1;
    for (int i = 0; i < e; i++) r = r * 10;
    return r;
  endfunction

endpackage

// File: rtl/bds_rst_sync.sv
module bds_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bds_place_ctrl.sv
module bds_place_ctrl
  import bds_pkg::*;
#(
  parameter int IN_W    = 8,
  parameter int NUM_DIG = 3,
  parameter int IDX_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            less_i,
  output logic [IN_W-1:0] pow_o,
  output logic            run_o,
  output logic            emit_o,
  output logic            last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIG - 1);

  conv_state_e     state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IN_W-1:0]  pow_tab [NUM_DIG];

  // Power-of-ten table: place 0 holds the highest power.
  for (genvar g = 0; g < NUM_DIG; g++) begin : g_pow
    assign pow_tab[g] = IN_W'(pow10(NUM_DIG - 1 - g));
  end

  assign pow_o  = pow_tab[idx_q];
  assign run_o  = (state_q == ST_RUN) && !load_i;
  assign emit_o = run_o && less_i;
  assign last_o = (idx_q == LAST_IDX);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (load_i) begin
      state_d = ST_RUN;
      idx_d   = '0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (less_i) begin
            if (last_o) begin
              state_d = ST_IDLE;
              idx_d   = '0;
            end else begin
              state_d = ST_GAP;
              idx_d   = idx_q + IDX_W'(1);
            end
          end
        end
        ST_GAP:  state_d = ST_RUN;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/bds_sub_unit.sv
module bds_sub_unit #(
  parameter int IN_W  = 8,
  parameter int DIG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [IN_W-1:0]  value_i,
  input  logic [IN_W-1:0]  pow_i,
  input  logic             run_i,
  output logic             less_o,
  output logic [DIG_W-1:0] count_o
);
  logic [IN_W-1:0]  rem_q, rem_d;
  logic [DIG_W-1:0] cnt_q, cnt_d;
  logic             rem_en, sub_en;

  assign less_o  = (rem_q < pow_i);
  assign count_o = cnt_q;
  assign sub_en  = run_i && !less_o;
  assign rem_en  = load_i || sub_en;

  always_comb begin
    rem_d = rem_q;
    cnt_d = cnt_q;
    if (load_i) begin
      rem_d = value_i;
      cnt_d = '0;
    end else if (sub_en) begin
      rem_d = rem_q - pow_i;
      cnt_d = cnt_q + DIG_W'(1);
    end else if (run_i) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bds_out_stage.sv
module bds_out_stage #(
  parameter int DIG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             emit_i,
  input  logic             last_i,
  input  logic [DIG_W-1:0] count_i,
  output logic [DIG_W-1:0] digit_o,
  output logic             vld_o,
  output logic             done_o
);
  logic [DIG_W-1:0] digit_q, digit_d;
  logic             vld_d, done_d;
  logic             vld_q, done_q;

  always_comb begin
    digit_d = digit_q;
    vld_d   = 1'b0;
    done_d  = done_q;
    if (load_i) begin
      digit_d = '0;
      done_d  = 1'b0;
    end else if (emit_i) begin
      digit_d = count_i;
      vld_d   = 1'b1;
      if (last_i) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digit_q <= '0;
      vld_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      digit_q <= digit_d;
      vld_q   <= vld_d;
      done_q  <= done_d;
    end
  end

  assign digit_o = digit_q;
  assign vld_o   = vld_q;
  assign done_o  = done_q;
endmodule

// File: rtl/bin_dec_serial.sv
module bin_dec_serial
  import bds_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int DIG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [IN_W-1:0]  value_i,
  output logic [DIG_W-1:0] digit_o,
  output logic             digit_vld_o,
  output logic             done_o
);
  localparam int NUM_DIG = digits_for_width(IN_W);
  localparam int IDX_W   = (NUM_DIG > 1) ? $clog2(NUM_DIG) : 1;

  logic             rst_n_int;
  logic [IN_W-1:0]  pow;
  logic             run, emit, last, less;
  logic [DIG_W-1:0] count;

  bds_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  bds_place_ctrl #(.IN_W(IN_W), .NUM_DIG(NUM_DIG), .IDX_W(IDX_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load_i (load_i),
    .less_i (less),
    .pow_o  (pow),
    .run_o  (run),
    .emit_o (emit),
    .last_o (last)
  );

  bds_sub_unit #(.IN_W(IN_W), .DIG_W(DIG_W)) u_sub (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load_i  (load_i),
    .value_i (value_i),
    .pow_i   (pow),
    .run_i   (run),
    .less_o  (less),
    .count_o (count)
  );

  bds_out_stage #(.DIG_W(DIG_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load_i  (load_i),
    .emit_i  (emit),
    .last_i  (last),
    .count_i (count),
    .digit_o (digit_o),
    .vld_o   (digit_vld_o),
    .done_o  (done_o)
  );
endmodule

// File: rtl/bin_dec_serial_chk.sv
module bin_dec_serial_chk #(
  parameter int IN_W  = 8,
  parameter int DIG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic [IN_W-1:0]  value_i,
  input logic [DIG_W-1:0] digit_o,
  input logic             digit_vld_o,
  input logic             done_o
);
  // R3
  no_double_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digit_vld_o |=> !digit_vld_o);

  // R6
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (digit_o == '0 && !digit_vld_o && !done_o));

  // R7
  digit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i ##1 !digit_vld_o) |-> $stable(digit_o));

  // R4
  done_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> digit_vld_o);

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> done_o);

  // R2
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digit_vld_o |-> (digit_o <= DIG_W'(9)));
endmodule

bind bin_dec_serial bin_dec_serial_chk #(.IN_W(IN_W), .DIG_W(DIG_W)) u_chk (.*);

// File: tb/sim_bin_dec_serial.sv
module sim_bin_dec_serial;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] value_i = '0;
  logic [3:0] digit_o;
  logic       digit_vld_o;
  logic       done_o;

  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  // behavioural reference
  int exp_digit = 0;
  bit exp_vld = 0, exp_done = 0, active = 0;
  int wait_cnt = 0;
  int digq[$];
  bit prev_vld = 0, prev_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bin_dec_serial u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .value_i(value_i),
    .digit_o(digit_o), .digit_vld_o(digit_vld_o), .done_o(done_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    exp_digit = 0; exp_vld = 0; exp_done = 0; active = 0;
    digq.delete();
  endtask

  task automatic model_step(input bit ld, input int v);
    if (ld) begin
      model_reset();
      digq.push_back(v / 100);
      digq.push_back((v / 10) % 10);
      digq.push_back(v % 10);
      wait_cnt = digq[0] + 1;
      active = 1;
    end else begin
      exp_vld = 0;
      if (active) begin
        wait_cnt--;
        if (wait_cnt == 0) begin
          exp_digit = digq.pop_front();
          exp_vld = 1;
          if (digq.size() == 0) begin
            exp_done = 1;
            active = 0;
          end else begin
            wait_cnt = digq[0] + 2;
          end
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "digit_o", digit_o, exp_digit);
    check(tag, "digit_vld_o", digit_vld_o, exp_vld);
    check(tag, "done_o", done_o, exp_done);
    check("R3", "consecutive strobe", int'(prev_vld && digit_vld_o), 0);
    if (done_o && !prev_done)
      check("R4", "strobe with done rise", digit_vld_o, 1);
    prev_vld = digit_vld_o;
    prev_done = done_o;
  endtask

  task automatic cycle(input bit ld, input int v, input string tag);
    load_i = ld;
    value_i = 8'(v);
    @(posedge clk);
    #1;
    model_step(ld, v);
    load_i = 0;
    compare(tag);
  endtask

  task automatic run_value(input int v);
    cycle(1, v, "R6");
    for (int i = 0; i < 40 && !exp_done; i++) cycle(0, 0, "R5");
    cycle(0, 0, "R4");
    for (int i = 0; i < 3; i++) cycle(0, 0, "R7");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      compare("R1");
    end
    rst_n = 1;
    for (int i = 0; i < 4; i++) cycle(0, 0, "R1");

    // R2 / R5: several input patterns incl. leading zeros
    run_value(0);
    run_value(9);
    run_value(10);
    run_value(99);
    run_value(100);
    run_value(255);
    run_value(137);
    run_value(200);

    // R8: abort mid-conversion
    cycle(1, 255, "R8");
    for (int i = 0; i < 9; i++) cycle(0, 0, "R8");
    cycle(1, 42, "R8");
    for (int i = 0; i < 40 && !exp_done; i++) cycle(0, 0, "R8");
    cycle(0, 0, "R8");
    // R8: load right after done
    run_value(7);

    // R1: asynchronous reset in mid-conversion
    cycle(1, 188, "R6");
    for (int i = 0; i < 6; i++) cycle(0, 0, "R5");
    @(negedge clk);
    rst_n = 0;
    #1;
    model_reset();
    compare("R1");
    for (int i = 0; i < 2; i++) cycle(0, 0, "R1");
    rst_n = 1;
    for (int i = 0; i < 4; i++) cycle(0, 0, "R1");
    run_value(61);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule